// File: doc/BRIEF.md
# Double-Buffered Framebuffer Scanout Engine

This block produces the raster for a small video subsystem. It runs a horizontal and a vertical dot counter. For every dot inside the visible window it forms a byte address into one 64 KB half of a 128 KB framebuffer. It turns the returned byte, or one nibble of it, into an index for a 256-entry colour RAM, and it presents the 16-bit colour read from that RAM as the output pixel. Both RAM arrays sit outside the block. The block drives their read addresses and takes their read data one clock later.

Software controls the block through two write ports. A 16-bit mode word chooses whether the display is on, whether pixels are 4 or 8 bits deep, whether the vertical interrupt is raised, which 16-colour group 4-bit pixels use, how many lines are blanked at the top and bottom of the picture, and which 64 KB half is shown. A second word gives the byte offset where scanning starts. Blanking lines moves both the vertical-blank status and the interrupt. The block reports the opposite half as the back buffer, which is the only half the CPU may touch.

Top module: `fb_scanout`

## Requirements
- R1: `hcount` counts 0 to H_TOTAL-1 and then returns to 0. `vcount` counts 0 to V_TOTAL-1, wraps to 0, and steps only on the clock where `hcount` wraps.
- R2: `pix_color` shows the colour RAM data for the dot whose counters were on `hcount`/`vcount` three clocks earlier. The path is: address, framebuffer read, colour RAM read, output register.
- R3: When the display enable (mode bit 15) is 0, or the dot lies at `hcount` >= H_ACT or `vcount` >= V_ACT, the colour index is 0.
- R4: With top count T (mode bits 10:6) and bottom count B (mode bits 5:1), only lines with T <= `vcount` < V_ACT-B are drawn. All other lines use colour index 0.
- R5: With mode bit 14 = 1 (8 bits per pixel), the sum S = offset + (`vcount`-T)*H_ACT + `hcount` is taken modulo 65536. The framebuffer byte at that position is used directly as the colour index.
- R6: With mode bit 14 = 0 (4 bits per pixel), the byte read is at (S >> 1) modulo 65536. An even S uses the high nibble and an odd S uses the low nibble. The colour index is group*16 + nibble, where the group is mode bits 12:11.
- R7: `fb_addr` bit 16 equals the front select (mode bit 0; 0 = lower half, 1 = upper half). `back_half` is its inverse.
- R8: `vblank` is set by the clock at the end of the `hcount`=0 dot of line V_ACT-B. It is cleared by the same clock on line T. If both apply on one line, setting wins.
- R9: `vint_req` is high exactly when `vblank` is high and the interrupt enable (mode bit 13) is 1.
- R10: Mode and offset writes are held in a shadow register. They take effect on the next horizontal wrap, so `back_half`, the drawing mode and the offset never change within a line. A write on the wrap clock itself waits for the following wrap.
- R11: After reset the counters are 0, `vblank`, `vint_req` and `pix_color` are 0, the display is off, and `back_half` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 16 | Mode word |
| offs_we | input | 1 | Write strobe for the start offset |
| offs_wdata | input | OFS_W (16) | Start byte offset |
| fb_addr | output | OFS_W+1 (17) | Framebuffer byte read address, top bit selects the half |
| fb_rdata | input | 8 | Framebuffer read data, one clock after the address |
| cram_addr | output | 8 | Colour RAM read index |
| cram_rdata | input | COL_W (16) | Colour RAM read data, one clock after the index |
| pix_color | output | COL_W (16) | Output pixel colour |
| hcount | output | clog2(H_TOTAL) (9) | Horizontal dot counter |
| vcount | output | clog2(V_TOTAL) (9) | Vertical line counter |
| vblank | output | 1 | Vertical blank status, also the pending interrupt |
| vint_req | output | 1 | Vertical interrupt request |
| back_half | output | 1 | Half of the framebuffer open to the CPU |

## Verification
The assertions assume that both external RAMs return their data exactly one clock after the address and that H_TOTAL exceeds H_ACT by at least two dots. The bench meets this with registered behavioural RAM models whose contents are computed from the address. The assertions also assume that the bottom count never exceeds V_ACT. The bench keeps every mode word it writes inside the reduced frame it instantiates. Mode writes are issued both in the middle of a line and on the wrap clock, so that the deferred update is exercised at its boundary.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

  // Field order follows the mode word bit positions (MSB first)
  typedef struct packed {
    logic       en;       // 15
    logic       deep;     // 14: 1 = 8 bits per pixel
    logic       irq_en;   // 13
    logic [1:0] grp;      // 12:11 colour group for 4-bit pixels
    logic [4:0] top;      // 10:6 blanked lines at top
    logic [4:0] bot;      // 5:1 blanked lines at bottom
    logic       front;    // 0 shown half
  } scan_mode_t;

  localparam int MODE_W = $bits(scan_mode_t);
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int CIDX_W = 8;

endpackage

// File: rtl/scan_rst_sync.sv
`timescale 1ns/1ps
module scan_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/scan_timing.sv
`timescale 1ns/1ps
module scan_timing #(
  parameter int H_TOTAL = 416,
  parameter int V_TOTAL = 262,
  parameter int HW      = $clog2(H_TOTAL),
  parameter int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          line_first,
  output logic          line_last
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic [HW-1:0] h_q, h_nxt;
  logic [VW-1:0] v_q, v_nxt;
  logic          tick_en;

  assign tick_en = 1'b1;

  always_comb begin
    h_nxt = h_q;
    v_nxt = v_q;
    if (tick_en) begin
      if (h_q == H_LAST) begin
        h_nxt = '0;
        v_nxt = (v_q == V_LAST) ? '0 : v_q + VW'(1);
      end else begin
        h_nxt = h_q + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_nxt;
      v_q <= v_nxt;
    end
  end

  assign hcnt       = h_q;
  assign vcnt       = v_q;
  assign line_first = (h_q == '0);
  assign line_last  = (h_q == H_LAST);
endmodule

// File: rtl/scan_ctrl.sv
`timescale 1ns/1ps
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int V_ACT = 240,
  parameter int VW    = 9,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic             offs_we,
  input  logic [OFS_W-1:0] offs_wdata,
  input  logic             line_first,
  input  logic             line_last,
  input  logic [VW-1:0]    vcnt,
  output scan_mode_t       act_mode,
  output logic [OFS_W-1:0] act_offs,
  output logic             vblank
);
  localparam int CW = ((VW > 5) ? VW : 5) + 1;

  scan_mode_t       shadow_q, shadow_nxt, act_q, act_nxt;
  logic [OFS_W-1:0] offs_sh_q, offs_sh_nxt, offs_q, offs_nxt;
  logic             vbl_q, vbl_nxt;
  logic [CW-1:0]    v_ext, set_line, clr_line;

  assign v_ext    = CW'(vcnt);
  assign set_line = CW'(V_ACT) - CW'(act_q.bot);
  assign clr_line = CW'(act_q.top);

  always_comb begin
    shadow_nxt  = shadow_q;
    offs_sh_nxt = offs_sh_q;
    act_nxt     = act_q;
    offs_nxt    = offs_q;
    vbl_nxt     = vbl_q;
    if (mode_we) shadow_nxt  = scan_mode_t'(mode_wdata);
    if (offs_we) offs_sh_nxt = offs_wdata;
    // shadow copied at the wrap: old shadow value, a write on this clock waits
    if (line_last) begin
      act_nxt  = shadow_q;
      offs_nxt = offs_sh_q;
    end
    if (line_first) begin
      if (v_ext == set_line)      vbl_nxt = 1'b1;
      else if (v_ext == clr_line) vbl_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      offs_sh_q <= '0;
      act_q     <= '0;
      offs_q    <= '0;
      vbl_q     <= 1'b0;
    end else begin
      shadow_q  <= shadow_nxt;
      offs_sh_q <= offs_sh_nxt;
      act_q     <= act_nxt;
      offs_q    <= offs_nxt;
      vbl_q     <= vbl_nxt;
    end
  end

  assign act_mode = act_q;
  assign act_offs = offs_q;
  assign vblank   = vbl_q;
endmodule

// File: rtl/scan_fetch.sv
`timescale 1ns/1ps
module scan_fetch
  import scan_pkg::*;
#(
  parameter int H_ACT = 320,
  parameter int V_ACT = 240,
  parameter int HW    = 9,
  parameter int VW    = 9,
  parameter int OFS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW-1:0]     hcnt,
  input  logic [VW-1:0]     vcnt,
  input  logic              en,
  input  logic              deep,
  input  logic [1:0]        grp,
  input  logic [4:0]        top,
  input  logic [4:0]        bot,
  input  logic              front,
  input  logic [OFS_W-1:0]  offs,
  input  logic [BYTE_W-1:0] fb_rdata,
  output logic [OFS_W:0]    fb_addr,
  output logic [CIDX_W-1:0] cram_addr
);
  localparam int SW    = OFS_W + 1;
  localparam int CW    = ((VW > 5) ? VW : 5) + 1;
  localparam int NNIB  = BYTE_W / NIB_W;

  logic [CW-1:0]    v_ext, top_ext, bot_ext, rel;
  logic             in_h, in_v, vis;
  logic [SW-1:0]    sum;
  logic [OFS_W-1:0] byte_idx;

  // stage 1: state of the dot whose framebuffer byte is arriving
  logic             s1_vis_q, s1_deep_q, s1_odd_q;
  logic [1:0]       s1_grp_q;
  logic             s1_vis_nxt, s1_deep_nxt, s1_odd_nxt;
  logic [1:0]       s1_grp_nxt;

  logic [NIB_W-1:0] nib_opt [NNIB];
  logic [NIB_W-1:0] nib_sel;

  assign v_ext   = CW'(vcnt);
  assign top_ext = CW'(top);
  assign bot_ext = CW'(bot);
  assign in_h    = (hcnt < HW'(H_ACT));
  assign in_v    = (v_ext < CW'(V_ACT)) && (v_ext >= top_ext) &&
                   ((v_ext + bot_ext) < CW'(V_ACT));
  assign vis     = en && in_h && in_v;
  assign rel     = v_ext - top_ext;

  always_comb begin
    sum      = SW'(offs) + SW'(rel) * SW'(H_ACT) + SW'(hcnt);
    byte_idx = deep ? sum[OFS_W-1:0] : sum[OFS_W:1];
  end

  assign fb_addr = {front, byte_idx};

  always_comb begin
    s1_vis_nxt  = vis;
    s1_deep_nxt = deep;
    s1_odd_nxt  = sum[0];
    s1_grp_nxt  = grp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vis_q  <= 1'b0;
      s1_deep_q <= 1'b0;
      s1_odd_q  <= 1'b0;
      s1_grp_q  <= '0;
    end else begin
      s1_vis_q  <= s1_vis_nxt;
      s1_deep_q <= s1_deep_nxt;
      s1_odd_q  <= s1_odd_nxt;
      s1_grp_q  <= s1_grp_nxt;
    end
  end

  // nibble slices, index 0 = low nibble
  for (genvar n = 0; n < NNIB; n++) begin : g_nib
    assign nib_opt[n] = fb_rdata[n*NIB_W +: NIB_W];
  end

  // even sum takes the high nibble (left dot of the pair)
  assign nib_sel = s1_odd_q ? nib_opt[0] : nib_opt[NNIB-1];

  always_comb begin
    if (!s1_vis_q)      cram_addr = '0;
    else if (s1_deep_q) cram_addr = fb_rdata;
    else                cram_addr = {2'b00, s1_grp_q, nib_sel};
  end
endmodule

// File: rtl/fb_scanout.sv
`timescale 1ns/1ps
module fb_scanout
  import scan_pkg::*;
#(
  parameter int H_TOTAL = 416,
  parameter int H_ACT   = 320,
  parameter int V_TOTAL = 262,
  parameter int V_ACT   = 240,
  parameter int OFS_W   = 16,
  parameter int COL_W   = 16,
  localparam int HW     = $clog2(H_TOTAL),
  localparam int VW     = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [15:0]       mode_wdata,
  input  logic              offs_we,
  input  logic [OFS_W-1:0]  offs_wdata,
  output logic [OFS_W:0]    fb_addr,
  input  logic [7:0]        fb_rdata,
  output logic [7:0]        cram_addr,
  input  logic [COL_W-1:0]  cram_rdata,
  output logic [COL_W-1:0]  pix_color,
  output logic [HW-1:0]     hcount,
  output logic [VW-1:0]     vcount,
  output logic              vblank,
  output logic              vint_req,
  output logic              back_half
);
  logic             rst_int_n;
  logic             line_first, line_last;
  scan_mode_t       act_mode;
  logic [OFS_W-1:0] act_offs;
  logic [COL_W-1:0] pix_q, pix_nxt;
  logic             vbl;

  scan_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  scan_timing #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL),
    .HW      (HW),
    .VW      (VW)
  ) u_timing (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hcnt       (hcount),
    .vcnt       (vcount),
    .line_first (line_first),
    .line_last  (line_last)
  );

  scan_ctrl #(
    .V_ACT (V_ACT),
    .VW    (VW),
    .OFS_W (OFS_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .offs_we    (offs_we),
    .offs_wdata (offs_wdata),
    .line_first (line_first),
    .line_last  (line_last),
    .vcnt       (vcount),
    .act_mode   (act_mode),
    .act_offs   (act_offs),
    .vblank     (vbl)
  );

  scan_fetch #(
    .H_ACT (H_ACT),
    .V_ACT (V_ACT),
    .HW    (HW),
    .VW    (VW),
    .OFS_W (OFS_W)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hcnt      (hcount),
    .vcnt      (vcount),
    .en        (act_mode.en),
    .deep      (act_mode.deep),
    .grp       (act_mode.grp),
    .top       (act_mode.top),
    .bot       (act_mode.bot),
    .front     (act_mode.front),
    .offs      (act_offs),
    .fb_rdata  (fb_rdata),
    .fb_addr   (fb_addr),
    .cram_addr (cram_addr)
  );

  assign pix_nxt = cram_rdata;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pix_q <= '0;
    else            pix_q <= pix_nxt;
  end

  assign pix_color = pix_q;
  assign vblank    = vbl;
  assign vint_req  = vbl & act_mode.irq_en;
  assign back_half = ~act_mode.front;
endmodule

// File: rtl/scan_chk.sv
`timescale 1ns/1ps
module scan_chk #(
  parameter int H_TOTAL = 416,
  parameter int H_ACT   = 320,
  parameter int V_TOTAL = 262,
  parameter int OFS_W   = 16,
  parameter int HW      = 9,
  parameter int VW      = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hcount,
  input logic [VW-1:0] vcount,
  input logic [OFS_W:0] fb_addr,
  input logic [7:0]    cram_addr,
  input logic          vblank,
  input logic          vint_req,
  input logic          back_half
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  // R1
  h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcount <= H_LAST);

  // R1
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount == H_LAST) |=> (hcount == '0));

  // R1
  v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount == H_LAST && vcount != V_LAST) |=> (vcount == $past(vcount) + VW'(1)));

  // R3
  blank_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount > HW'(H_ACT)) |-> (cram_addr == '0));

  // R7
  front_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_addr[OFS_W] != back_half);

  // R10
  back_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount != '0) |-> $stable(back_half));

  // R8
  vblank_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank != $past(vblank)) |-> (hcount == HW'(1)));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vint_req |-> vblank);
endmodule

bind fb_scanout scan_chk #(
  .H_TOTAL (H_TOTAL),
  .H_ACT   (H_ACT),
  .V_TOTAL (V_TOTAL),
  .OFS_W   (OFS_W),
  .HW      (HW),
  .VW      (VW)
) i_scan_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hcount    (hcount),
  .vcount    (vcount),
  .fb_addr   (fb_addr),
  .cram_addr (cram_addr),
  .vblank    (vblank),
  .vint_req  (vint_req),
  .back_half (back_half)
);

// File: tb/test_fb_scanout.sv
`timescale 1ns/1ps
module test_fb_scanout;
  localparam int HT = 40;
  localparam int HA = 32;
  localparam int VT = 30;
  localparam int VA = 24;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);

  logic        clk;
  logic        rst_n;
  logic        mode_we;
  logic [15:0] mode_wdata;
  logic        offs_we;
  logic [15:0] offs_wdata;
  logic [16:0] fb_addr;
  logic [7:0]  fb_rdata;
  logic [7:0]  cram_addr;
  logic [15:0] cram_rdata;
  logic [15:0] pix_color;
  logic [HW-1:0] hcount;
  logic [VW-1:0] vcount;
  logic        vblank;
  logic        vint_req;
  logic        back_half;

  fb_scanout #(.H_TOTAL(HT), .H_ACT(HA), .V_TOTAL(VT), .V_ACT(VA)) i_fb_scanout (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .offs_we(offs_we), .offs_wdata(offs_wdata), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
    .cram_addr(cram_addr), .cram_rdata(cram_rdata), .pix_color(pix_color),
    .hcount(hcount), .vcount(vcount), .vblank(vblank), .vint_req(vint_req),
    .back_half(back_half)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // computed RAM contents
  function automatic int fbv(input int a);
    int b;
    b = (a & 255) ^ ((a >> 8) & 255);
    if (((a >> 16) & 1) != 0) b = b ^ 'h5A;
    return b;
  endfunction

  function automatic int cval(input int i);
    return (((i ^ 'hC3) & 255) << 8) | (i & 255);
  endfunction

  always @(posedge clk) begin
    fb_rdata   <= 8'(fbv(int'(fb_addr)));
    cram_rdata <= 16'(cval(int'(cram_addr)));
  end

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // reference model state
  int mh, mv, mvb, rel_n;
  int ma, mp, moa, mop;
  int pq[$];
  string tq[$];

  function automatic void model_reset();
    mh = 0; mv = 0; mvb = 0;
    ma = 0; mp = 0; moa = 0; mop = 0;
    pq = {};
    tq = {};
    repeat (3) begin
      pq.push_back(cval(0));
      tq.push_back("R11");
    end
  endfunction

  function automatic int exp_pix(output string tag);
    int en, deep, grp, top, bot, fr, s, b, idx;
    en = (ma >> 15) & 1; deep = (ma >> 14) & 1; grp = (ma >> 11) & 3;
    top = (ma >> 6) & 31; bot = (ma >> 1) & 31; fr = ma & 1;
    if (en == 0 || mh >= HA || mv >= VA) begin
      idx = 0; tag = "R3";
    end else if (mv < top || mv + bot >= VA) begin
      idx = 0; tag = "R4";
    end else begin
      s = moa + (mv - top) * HA + mh;
      if (deep != 0) begin
        idx = fbv((fr << 16) | (s & 'hFFFF));
        tag = "R5";
      end else begin
        b = fbv((fr << 16) | ((s >> 1) & 'hFFFF));
        idx = grp * 16 + (((s & 1) != 0) ? (b & 15) : (b >> 4));
        tag = "R6";
      end
    end
    return cval(idx);
  endfunction

  function automatic void model_step();
    int top, bot;
    top = (ma >> 6) & 31; bot = (ma >> 1) & 31;
    if (mh == 0) begin
      if (mv == VA - bot)  mvb = 1;
      else if (mv == top)  mvb = 0;
    end
    if (mh == HT - 1) begin
      ma = mp; moa = mop;
    end
    if (mode_we) mp = int'(mode_wdata);
    if (offs_we) mop = int'(offs_wdata);
    if (mh == HT - 1) begin
      mh = 0;
      mv = (mv == VT - 1) ? 0 : mv + 1;
    end else begin
      mh = mh + 1;
    end
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      rel_n = 0;
      model_reset();
      chk(hcount == 0 && vcount == 0, "R11 counters", int'({hcount, vcount}), 0);
      chk(vblank == 0 && vint_req == 0, "R11 flags", int'({vblank, vint_req}), 0);
      chk(back_half == 1'b1, "R11 back_half", int'(back_half), 1);
      chk(pix_color == 0, "R11 pix_color", int'(pix_color), 0);
    end else begin
      rel_n++;
      if (rel_n <= 2) model_reset();
      else begin
        string tg;
        int ep;
        model_step();
        chk(int'(hcount) == mh, "R1 hcount", int'(hcount), mh);
        chk(int'(vcount) == mv, "R1 vcount", int'(vcount), mv);
        chk(int'(vblank) == mvb, "R8 vblank", int'(vblank), mvb);
        chk(int'(vint_req) == (mvb & ((ma >> 13) & 1)), "R9 vint_req",
            int'(vint_req), mvb & ((ma >> 13) & 1));
        chk(int'(back_half) == (1 - (ma & 1)), "R7 R10 back_half",
            int'(back_half), 1 - (ma & 1));
        ep = pq.pop_front();
        tg = tq.pop_front();
        chk(int'(pix_color) == ep, {"R2 pixel ", tg}, int'(pix_color), ep);
        ep = exp_pix(tg);
        pq.push_back(ep);
        tq.push_back(tg);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [15:0] w);
    @(negedge clk); #1;
    mode_we = 1'b1; mode_wdata = w;
    @(negedge clk); #1;
    mode_we = 1'b0;
  endtask

  task automatic wr_offs(input logic [15:0] w);
    @(negedge clk); #1;
    offs_we = 1'b1; offs_wdata = w;
    @(negedge clk); #1;
    offs_we = 1'b0;
  endtask

  // R10: write lands on the wrap clock itself
  task automatic wr_mode_at_wrap(input logic [15:0] w);
    @(negedge clk);
    while (int'(hcount) != HT - 1) @(negedge clk);
    #1;
    mode_we = 1'b1; mode_wdata = w;
    @(negedge clk); #1;
    mode_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b1;
    mode_we = 1'b0; mode_wdata = '0;
    offs_we = 1'b0; offs_wdata = '0;
    #2 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    run(1300);                    // R3 display off
    wr_offs(16'h0000);
    wr_mode(16'hE000);            // R5 8 bpp, irq on, no letterbox
    run(2500);
    wr_offs(16'h0005);            // R6 odd start offset
    wr_mode_at_wrap(16'hB0C9);    // R6 R4 R7 R10 4 bpp group 2, top 3, bottom 4, upper half
    run(2500);
    wr_offs(16'hFFF0);            // R5 offset wraps within the half
    wr_mode(16'hC144);            // R4 8 bpp top 5 bottom 2, irq off
    run(2500);
    wr_offs(16'hFFFF);
    wr_mode(16'hBA9D);            // R8 set and clear on one line, group 3
    run(2500);
    wr_mode_at_wrap(16'h0042);    // R3 disabled with letterbox fields
    run(1300);
    wr_mode(16'hE000);
    run(1300);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule